// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block generates a pulse-width modulated waveform whose period is set by an 8-bit timer. The timer steps once per prescaled group of four input clocks. A 2-bit sub-count runs below the timer on every input clock. The comparison is made at 10 bits, between the active duty value and the timer with the sub-count appended, so the duty resolution is four times finer than the timer step.

Software loads the period, the upper eight duty bits and a control byte through a single-cycle write port. It may do so at any moment. The duty value written is held in a buffer and becomes active only when a period ends, so the waveform never carries a half-updated duty.

A steering stage maps the waveform onto four output pins. A 2-bit mode field chooses single, half-bridge, forward full-bridge or reverse full-bridge drive.

Top module: `pwm10_dbuf`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `pwm_o` and all four bits of `pins_o` are 0.
- R2: A write with `wr_en` high stores `wr_data` at the next rising clock. The address selects the target:
  - Address 0 is the period.
  - Address 1 is duty bits [9:2].
  - Address 2 is the control byte. Its bits [1:0] are duty bits [1:0], bits [3:2] are the steering mode and bits [5:4] are the prescale select.
- R3: The sub-count advances on every clock. The timer advances each time the sub-count wraps and the prescale count has reached its last value. Prescale select 0 divides by 1, select 1 by 4, and selects 2 and 3 by 16. One period therefore lasts 4 × (period + 1) × prescale clocks.
- R4: A duty value written during a period has no effect on that period. It becomes active in the cycle after the timer step at which the timer equals the period.
- R5: The output is high from the first cycle of a period until the first cycle in which {timer, sub-count} equals the active duty D. With prescale P that is (D div 4)·4·P + (D mod 4) cycles.
- R6: An active duty of 0 keeps `pwm_o` low for the whole period.
- R7: An active duty greater than 4·period + 3 keeps `pwm_o` high for the whole period.
- R8: In mode 0 (single), pin A (bit 0) follows the waveform and bits 3:1 are 0.
- R9: In mode 1 (half-bridge), pin A follows the waveform, pin B (bit 1) is its complement, and bits 3:2 are 0.
- R10: In mode 2 (forward full-bridge), pin A is 1, pin D (bit 3) follows the waveform, and pins B and C are 0.
- R11: In mode 3 (reverse full-bridge), pin C (bit 2) is 1, pin B follows the waveform, and pins A and D are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_o | output | 1 | Raw waveform |
| pins_o | output | 4 | Steered pins, bit 0 = A through bit 3 = D |

## Verification
The hardest case to reach is a duty update that lands in the middle of a period. To reach it, the bench starts a period with one duty value and writes both duty registers a few cycles into that period. It then counts the high cycles of that period and of the next one separately. Prescale changes are applied only at the first cycle of a period. In that cycle the sub-count and the prescale count are both zero, so a period can be measured under a divider of 4 or 16 with no partial prescale group. An independent clock-by-clock model follows the same periods throughout.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  localparam int PSC_W = 4;

  typedef enum logic [1:0] {
    OUT_SINGLE = 2'd0,
    OUT_HALF   = 2'd1,
    OUT_FWD    = 2'd2,
    OUT_REV    = 2'd3
  } steer_mode_t;

  // last prescale count value for a divider select
  function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] sel);
    case (sel)
      2'd0:    psc_last = PSC_W'(0);
      2'd1:    psc_last = PSC_W'(3);
      default: psc_last = PSC_W'(15);
    endcase
  endfunction

  // pin vector {D,C,B,A} for a mode and waveform level
  function automatic logic [3:0] steer_pins(input steer_mode_t m, input logic p);
    case (m)
      OUT_SINGLE: steer_pins = {3'b000, p};
      OUT_HALF:   steer_pins = {2'b00, ~p, p};
      OUT_FWD:    steer_pins = {p, 2'b00, 1'b1};
      default:    steer_pins = {1'b0, 1'b1, p, 1'b0};
    endcase
  endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs import pwm10_pkg::*; #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DW = TMR_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] period,
  output logic [DW-1:0]    duty_buf,
  output steer_mode_t      mode,
  output logic [1:0]       psel
);

  logic [TMR_W-1:0] duty_hi;
  logic [SUB_W-1:0] duty_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period  <= '0;
      duty_hi <= '0;
      duty_lo <= '0;
      mode    <= OUT_SINGLE;
      psel    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: period  <= wr_data;
        2'd1: duty_hi <= wr_data;
        2'd2: begin
          duty_lo <= wr_data[SUB_W-1:0];
          mode    <= steer_mode_t'(wr_data[3:2]);
          psel    <= wr_data[5:4];
        end
        default: ;
      endcase
    end
  end

  assign duty_buf = {duty_hi, duty_lo};

  // R2
  duty_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> (duty_buf[DW-1:SUB_W] == $past(wr_data)));

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase import pwm10_pkg::*; #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DW = TMR_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       psel,
  input  logic [TMR_W-1:0] period,
  output logic [DW-1:0]    pos,
  output logic             prd_end
);

  logic [SUB_W-1:0] sc;
  logic [PSC_W-1:0] pc;
  logic [TMR_W-1:0] tmr;

  wire sub_wrap = &sc;
  wire pre_done = (pc >= psc_last(psel));
  wire tmr_step = sub_wrap && pre_done;

  assign prd_end = tmr_step && (tmr == period);
  assign pos     = {tmr, sc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc  <= '0;
      pc  <= '0;
      tmr <= '0;
    end else begin
      sc <= sc + 1'b1;
      if (sub_wrap) pc <= pre_done ? '0 : pc + 1'b1;
      if (tmr_step) tmr <= prd_end ? '0 : tmr + 1'b1;
    end
  end

  // R3
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sc == SUB_W'($past(sc) + 1'b1)));

  // R3
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_wrap |=> $stable(tmr));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_end |=> (pos == '0));

endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prd_end,
  input  logic [DW-1:0] pos,
  input  logic [DW-1:0] duty_buf,
  output logic          pwm
);

  logic [DW-1:0] duty_act;
  logic          hold;

  wire hit = (pos == duty_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_act <= '0;
      hold     <= 1'b0;
    end else if (prd_end) begin
      duty_act <= duty_buf;
      hold     <= |duty_buf;
    end else if (hit) begin
      hold <= 1'b0;
    end
  end

  assign pwm = hold & ~hit;

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prd_end |=> $stable(duty_act));

  // R5
  low_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && !prd_end) |=> !pwm);

  // R5
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_end && duty_buf != '0) |=> pwm);

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_end && duty_buf == '0) |=> !pwm);

endmodule

// File: rtl/pwm10_steer.sv
module pwm10_steer import pwm10_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  steer_mode_t mode,
  input  logic        pwm,
  output logic [3:0]  pins
);

  assign pins = steer_pins(mode, pwm);

  // R8
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_SINGLE) |-> ($countones(pins[3:1]) == 0 && pins[0] == pwm));

  // R9
  half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_HALF) |-> ((pins[0] ^ pins[1]) && pins[3:2] == 2'b00));

  // R10
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_FWD) |-> (pins[0] && !pins[1] && !pins[2] && pins[3] == pwm));

  // R11
  rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_REV) |-> (!pins[0] && !pins[3] && pins[2] && pins[1] == pwm));

endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf import pwm10_pkg::*; #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DW = TMR_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic             pwm_o,
  output logic [3:0]       pins_o
);

  logic [TMR_W-1:0] period;
  logic [DW-1:0]    duty_buf;
  logic [DW-1:0]    pos;
  logic [1:0]       psel;
  logic             prd_end;
  steer_mode_t      mode;

  pwm10_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .duty_buf(duty_buf),
    .mode(mode), .psel(psel)
  );

  pwm10_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .psel(psel), .period(period),
    .pos(pos), .prd_end(prd_end)
  );

  pwm10_compare #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .prd_end(prd_end), .pos(pos),
    .duty_buf(duty_buf), .pwm(pwm_o)
  );

  pwm10_steer u_steer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwm(pwm_o), .pins(pins_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwm_o && pins_o == 4'b0000));

endmodule

// File: tb/sim_pwm10_dbuf.sv
`timescale 1ns/1ps
module sim_pwm10_dbuf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_o;
  logic [3:0] pins_o;

  always #2 clk = ~clk;

  pwm10_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .pins_o(pins_o)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_sub, m_pre, m_tim, m_per, m_dbuf, m_dact, m_mode, m_psel, ph;

  function automatic int pdiv(int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : 16;
  endfunction

  function automatic int hightime(int d, int per, int p);
    if (d > 4 * per + 3) return 1 << 30;
    return (d / 4) * 4 * p + (d % 4);
  endfunction

  function automatic logic [3:0] exp_pins(int mode, logic p);
    case (mode)
      0: return {3'b000, p};
      1: return {2'b00, ~p, p};
      2: return {p, 2'b00, 1'b1};
      default: return {1'b0, 1'b1, p, 1'b0};
    endcase
  endfunction

  task automatic chk(string req, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_sub = 0; m_pre = 0; m_tim = 0; m_per = 0; m_dbuf = 0;
      m_dact = 0; m_mode = 0; m_psel = 0; ph = 0;
    end else begin
      bit boundary;
      boundary = 0;
      if (m_sub == 3) begin
        if (m_pre >= pdiv(m_psel) - 1) begin
          m_pre = 0;
          if (m_tim == m_per) begin m_tim = 0; boundary = 1; end
          else m_tim = (m_tim + 1) % 256;
        end else m_pre++;
      end
      m_sub = (m_sub + 1) % 4;
      if (boundary) begin ph = 0; m_dact = m_dbuf; end
      else ph++;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_per = wr_data;
          2'd1: m_dbuf = (m_dbuf % 4) + 4 * wr_data;
          2'd2: begin
            m_dbuf = (m_dbuf / 4) * 4 + wr_data[1:0];
            m_mode = wr_data[3:2];
            m_psel = wr_data[5:4];
          end
          default: ;
        endcase
      end
    end
  end

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e;
      string tg;
      e = (ph < hightime(m_dact, m_per, pdiv(m_psel)));
      chk("R5 per-clock pwm_o", pwm_o, e);
      case (m_mode)
        0: tg = "R8 per-clock pins";
        1: tg = "R9 per-clock pins";
        2: tg = "R10 per-clock pins";
        default: tg = "R11 per-clock pins";
      endcase
      chk(tg, pins_o, exp_pins(m_mode, e));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (ph != 0);
  endtask

  task automatic cfg(int per, int psel, int mode, int d);
    wait_start();
    wr(0, per);
    wr(1, d / 4);
    wr(2, psel * 16 + mode * 4 + d % 4);
  endtask

  task automatic measure(string req, int len, int expct);
    int cnt = 0;
    wait_start();
    for (int i = 0; i < len; i++) begin
      if (pwm_o) cnt++;
      @(negedge clk);
    end
    chk(req, cnt, expct);
  endtask

  task automatic period_len(string req, int expct);
    int cnt = 0;
    logic prev;
    prev = pwm_o;
    while (!(pwm_o && !prev)) begin prev = pwm_o; @(negedge clk); end
    prev = pwm_o;
    @(negedge clk);
    cnt = 1;
    while (!(pwm_o && !prev)) begin prev = pwm_o; @(negedge clk); cnt++; end
    chk(req, cnt, expct);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pwm_o in reset", pwm_o, 0);
    chk("R1 pins_o in reset", pins_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm_o after reset", pwm_o, 0);
    chk("R1 pins_o after reset", pins_o, 0);

    cfg(9, 0, 0, 17);  measure("R2/R5 duty 17 high cycles", 40, 17);
    cfg(9, 0, 0, 1);   measure("R5 duty 1 high cycles", 40, 1);
    cfg(9, 0, 0, 0);   measure("R6 duty 0 high cycles", 40, 0);
    cfg(9, 0, 0, 45);  measure("R7 duty over period high cycles", 40, 40);
    cfg(9, 0, 0, 39);  measure("R7 duty at top position high cycles", 40, 39);
    cfg(3, 1, 0, 6);   measure("R3 prescale 4 high cycles", 64, 18);
    period_len("R3 prescale 4 period length", 64);
    cfg(1, 2, 0, 5);   measure("R3 prescale 16 high cycles", 128, 65);
    period_len("R3 prescale 16 period length", 128);

    // R4: write a new duty part way through a period
    cfg(9, 0, 0, 8);
    measure("R4 duty 8 before update", 40, 8);
    begin
      int cnt = 0;
      wait_start();
      for (int i = 0; i < 40; i++) begin
        if (pwm_o) cnt++;
        if (i == 5) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd7; end
        else if (i == 6) begin wr_addr = 2'd2; wr_data = 8'd2; end
        else if (i == 7) wr_en = 1'b0;
        @(negedge clk);
      end
      chk("R4 period with mid-period write keeps old duty", cnt, 8);
    end
    measure("R4 following period uses new duty", 40, 30);

    cfg(9, 0, 1, 17);  measure("R9 half-bridge high cycles", 40, 17);
    cfg(9, 0, 2, 13);  measure("R10 forward high cycles", 40, 13);
    cfg(9, 0, 3, 22);  measure("R11 reverse high cycles", 40, 22);
    cfg(9, 0, 0, 10);  measure("R8 single high cycles", 40, 10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule